// File: doc/BRIEF.md
# Segmented Pipelined Ternary Match Engine

This block is a ternary lookup table whose comparison is spread over a pipeline. Each stored entry holds a value, a per-bit care mask and a live flag. An incoming key is compared against every entry, but the key is cut into SEGS slices that are compared one slice per pipeline stage. An entry that fails a slice is dropped from all later stages. Rows are also gathered into groups of GROUP_ROWS. A group's local copy of a key slice is refreshed only when at least one of its rows is still a candidate, so a group with no candidates keeps its old slice.

A new key can enter every cycle, and the answer leaves SEGS cycles later. Each answer gives the full match vector, the lowest matching row and two activity totals: how many entry-slice comparisons were made, and how many local slice refreshes took place. These totals act as a cycle-level proxy for search power. The first slice can be made narrow, so most entries are dropped after a cheap compare. A table update waits until no key is in flight and blocks new keys while it is pending, so every key is compared against one consistent table.

Top module: `tmatch_pipe`

## Requirements
- R1: Row r appears in `rsp_vec` exactly when it is live and, for every key bit b, either its care bit b is 0 or its value bit b equals key bit b.
- R2: A key sampled with `srch_valid` high and `srch_ready` high at rising edge n gives `rsp_valid` high for exactly the cycle after edge n+SEGS. Keys are accepted on consecutive edges, and answers come back in order.
- R3: `rsp_hit` is the OR of `rsp_vec`. When a row matches, `rsp_idx` is the lowest set row of `rsp_vec`; otherwise it is 0.
- R4: The key is cut into slices. Slice 0 is bits [SEG0_W-1:0]. Slice k≥1 is the next (KEY_W-SEG0_W)/(SEGS-1) bits upward. A row takes part in slice k only if it is live and matched slices 0..k-1. `rsp_seg_evals` is the total number of such participations over all slices.
- R5: Rows r with r/GROUP_ROWS = g form group g. `rsp_grp_ens` counts, summed over all slices, the groups holding at least one row that takes part in that slice.
- R6: `srch_ready` is the inverse of `wr_en`. `wr_ack` is high only while `wr_en` is high and no accepted key is still inside the stages. It is high whenever both conditions hold. The write (value, care mask, live flag at `wr_addr`) takes effect at the edge where `wr_ack` is high, and later keys see it.
- R7: After reset, `rsp_valid` is low and no entry is live. A key then returns an empty vector and zero for both activity totals.
- R8: A key presented while `srch_ready` is low produces no answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_valid | input | 1 | Key present |
| srch_key | input | KEY_W (20) | Search key |
| srch_ready | output | 1 | Key can be taken this cycle |
| wr_en | input | 1 | Table update request, held until acknowledged |
| wr_addr | input | log2(WORDS) (4) | Row to update |
| wr_live | input | 1 | New live flag of the row |
| wr_value | input | KEY_W (20) | New value of the row |
| wr_care | input | KEY_W (20) | New care mask, 0 = wildcard bit |
| wr_ack | output | 1 | Update applied at this edge |
| rsp_valid | output | 1 | Answer present |
| rsp_hit | output | 1 | At least one row matched |
| rsp_idx | output | log2(WORDS) (4) | Lowest matching row |
| rsp_vec | output | WORDS (16) | Per-row match result |
| rsp_seg_evals | output | 7 | Entry-slice comparisons made for this key |
| rsp_grp_ens | output | 5 | Local slice refreshes made for this key |

## Verification
A candidate vector corrupted in a middle stage changes both the match vector and the activity totals of that key. This shows at the ports exactly SEGS cycles after the key was taken, and the neighbouring keys are unaffected. An error in group gating or in slice boundaries leaves most match vectors unchanged, so it shows mainly in `rsp_grp_ens` and `rsp_seg_evals`. Random tables with many wildcard bits, and keys that differ from a stored entry by a single bit, drive rows to drop out at every slice. A pipeline-occupancy error in the update handshake shows as an early or missing `wr_ack`, or as an answer built from a half-updated table.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;

   // lowest key bit covered by slice k
   function automatic int seg_lo(input int k, input int w0, input int wr);
      return (k == 0) ? 0 : w0 + (k - 1) * wr;
   endfunction

   // width of slice k
   function automatic int seg_w(input int k, input int w0, input int wr);
      return (k == 0) ? w0 : wr;
   endfunction

endpackage

// File: rtl/tmatch_table.sv
module tmatch_table #(
   parameter int WORDS = 16,
   parameter int KEY_W = 20,
   localparam int IW = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IW-1:0]      addr,
   input  logic               live_in,
   input  logic [KEY_W-1:0]   val_in,
   input  logic [KEY_W-1:0]   care_in,
   output logic [WORDS-1:0]   live,
   output logic [WORDS*KEY_W-1:0] val_flat,
   output logic [WORDS*KEY_W-1:0] care_flat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live      <= '0;
         val_flat  <= '0;
         care_flat <= '0;
      end else if (we) begin
         live[addr]                     <= live_in;
         // wildcard bits are stored with value 0
         val_flat[addr*KEY_W +: KEY_W]  <= val_in & care_in;
         care_flat[addr*KEY_W +: KEY_W] <= care_in;
      end
   end

   // R6: table contents move only on an acknowledged write
   p_table_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(live) && $stable(val_flat) && $stable(care_flat)));

endmodule

// File: rtl/tmatch_stage.sv
module tmatch_stage #(
   parameter int WORDS      = 16,
   parameter int SW         = 2,
   parameter int GROUP_ROWS = 4,
   localparam int GROUPS = WORDS / GROUP_ROWS,
   localparam int CW     = $clog2(WORDS + 1),
   localparam int GW     = $clog2(GROUPS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  act,
   input  logic [SW-1:0]         key,
   input  logic [WORDS-1:0]      surv_in,
   input  logic [WORDS*SW-1:0]   tab_val,
   input  logic [WORDS*SW-1:0]   tab_care,
   output logic [WORDS-1:0]      surv_out,
   output logic [CW-1:0]         n_eval,
   output logic [GW-1:0]         n_grp
);

   logic [GROUPS-1:0]         grp_en;
   logic [GROUPS-1:0][SW-1:0] lsl_q;
   logic [GROUPS-1:0][SW-1:0] lsl;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_en[g] = act && (|surv_in[g*GROUP_ROWS +: GROUP_ROWS]);
      assign lsl[g]    = grp_en[g] ? key : lsl_q[g];
   end

   // local slice copies keep their old value when their group is idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsl_q <= '0;
      end else begin
         for (int g = 0; g < GROUPS; g++) begin
            if (grp_en[g]) lsl_q[g] <= key;
         end
      end
   end

   for (genvar r = 0; r < WORDS; r++) begin : g_row
      localparam int G = r / GROUP_ROWS;
      logic row_ok;
      assign row_ok = &(~tab_care[r*SW +: SW] | ~(tab_val[r*SW +: SW] ^ lsl[G]));
      assign surv_out[r] = act && surv_in[r] && row_ok;
   end

   assign n_eval = act ? CW'($countones(surv_in)) : '0;
   assign n_grp  = GW'($countones(grp_en));

   // R5: a group is refreshed exactly when some row is compared
   p_grp_iff_eval_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> ((n_grp == '0) == (n_eval == '0)));

endmodule

// File: rtl/tmatch_prio.sv
module tmatch_prio #(
   parameter int WORDS = 16,
   localparam int IW = $clog2(WORDS)
) (
   input  logic [WORDS-1:0] vec,
   output logic             hit,
   output logic [IW-1:0]    idx
);

   always_comb begin
      idx = '0;
      for (int i = WORDS - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign hit = |vec;

endmodule

// File: rtl/tmatch_pipe.sv
module tmatch_pipe #(
   parameter int WORDS      = 16,
   parameter int KEY_W      = 20,
   parameter int SEG0_W     = 2,
   parameter int SEGS       = 4,
   parameter int GROUP_ROWS = 4
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    srch_valid,
   input  logic [KEY_W-1:0]                        srch_key,
   output logic                                    srch_ready,
   input  logic                                    wr_en,
   input  logic [$clog2(WORDS)-1:0]                wr_addr,
   input  logic                                    wr_live,
   input  logic [KEY_W-1:0]                        wr_value,
   input  logic [KEY_W-1:0]                        wr_care,
   output logic                                    wr_ack,
   output logic                                    rsp_valid,
   output logic                                    rsp_hit,
   output logic [$clog2(WORDS)-1:0]                rsp_idx,
   output logic [WORDS-1:0]                        rsp_vec,
   output logic [$clog2(WORDS*SEGS+1)-1:0]         rsp_seg_evals,
   output logic [$clog2((WORDS/GROUP_ROWS)*SEGS+1)-1:0] rsp_grp_ens
);

   localparam int IW     = $clog2(WORDS);
   localparam int GROUPS = WORDS / GROUP_ROWS;
   localparam int REST_W = (KEY_W - SEG0_W) / (SEGS - 1);
   localparam int CW     = $clog2(WORDS + 1);
   localparam int GW     = $clog2(GROUPS + 1);
   localparam int EV_W   = $clog2(WORDS * SEGS + 1);
   localparam int GE_W   = $clog2(GROUPS * SEGS + 1);

   // elaboration checks
   if (SEGS < 2) begin : g_chk_segs
      $error("tmatch_pipe: SEGS must be at least 2");
   end
   if (WORDS < 2 || (WORDS % GROUP_ROWS) != 0) begin : g_chk_rows
      $error("tmatch_pipe: WORDS must be >= 2 and a multiple of GROUP_ROWS");
   end
   if (SEG0_W < 1 || SEG0_W >= KEY_W || ((KEY_W - SEG0_W) % (SEGS - 1)) != 0) begin : g_chk_key
      $error("tmatch_pipe: KEY_W - SEG0_W must split evenly over SEGS-1 slices");
   end

   logic [WORDS-1:0]       live;
   logic [WORDS*KEY_W-1:0] tab_val;
   logic [WORDS*KEY_W-1:0] tab_care;
   logic [SEGS-1:0]        act_v;
   logic                   busy;

   assign busy       = |act_v;
   assign srch_ready = !wr_en;
   assign wr_ack     = wr_en && !busy;

   tmatch_table #(.WORDS(WORDS), .KEY_W(KEY_W)) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_ack),
      .addr     (wr_addr),
      .live_in  (wr_live),
      .val_in   (wr_value),
      .care_in  (wr_care),
      .live     (live),
      .val_flat (tab_val),
      .care_flat(tab_care)
   );

   for (genvar k = 0; k < SEGS; k++) begin : g_seg
      localparam int LO  = tmatch_pkg::seg_lo(k, SEG0_W, REST_W);
      localparam int SW  = tmatch_pkg::seg_w(k, SEG0_W, REST_W);
      localparam int REM = KEY_W - LO;

      logic                 act_q;
      logic [REM-1:0]       key_q;
      logic [WORDS-1:0]     surv_q;
      logic [WORDS-1:0]     surv_o;
      logic [EV_W-1:0]      ev_q;
      logic [GE_W-1:0]      ge_q;
      logic [CW-1:0]        n_ev;
      logic [GW-1:0]        n_ge;
      logic [WORDS*SW-1:0]  v_s;
      logic [WORDS*SW-1:0]  c_s;

      assign act_v[k] = act_q;

      for (genvar r = 0; r < WORDS; r++) begin : g_slice
         assign v_s[r*SW +: SW] = tab_val[r*KEY_W + LO +: SW];
         assign c_s[r*SW +: SW] = tab_care[r*KEY_W + LO +: SW];
      end

      if (k == 0) begin : g_in
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q  <= 1'b0;
               key_q  <= '0;
               surv_q <= '0;
            end else begin
               act_q  <= srch_valid && !wr_en;
               key_q  <= srch_key;
               surv_q <= live;
            end
         end
         assign ev_q = '0;
         assign ge_q = '0;
      end else begin : g_mid
         localparam int PLO = tmatch_pkg::seg_lo(k - 1, SEG0_W, REST_W);
         localparam int PSW = tmatch_pkg::seg_w(k - 1, SEG0_W, REST_W);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_q  <= 1'b0;
               key_q  <= '0;
               surv_q <= '0;
               ev_q   <= '0;
               ge_q   <= '0;
            end else begin
               act_q  <= g_seg[k-1].act_q;
               key_q  <= g_seg[k-1].key_q[KEY_W-PLO-1:PSW];
               surv_q <= g_seg[k-1].surv_o;
               ev_q   <= g_seg[k-1].ev_q + EV_W'(g_seg[k-1].n_ev);
               ge_q   <= g_seg[k-1].ge_q + GE_W'(g_seg[k-1].n_ge);
            end
         end
      end

      tmatch_stage #(.WORDS(WORDS), .SW(SW), .GROUP_ROWS(GROUP_ROWS)) i_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .act     (act_q),
         .key     (key_q[SW-1:0]),
         .surv_in (surv_q),
         .tab_val (v_s),
         .tab_care(c_s),
         .surv_out(surv_o),
         .n_eval  (n_ev),
         .n_grp   (n_ge)
      );
   end

   logic          f_hit;
   logic [IW-1:0] f_idx;

   tmatch_prio #(.WORDS(WORDS)) i_prio (
      .vec(g_seg[SEGS-1].surv_o),
      .hit(f_hit),
      .idx(f_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_idx       <= '0;
         rsp_vec       <= '0;
         rsp_seg_evals <= '0;
         rsp_grp_ens   <= '0;
      end else begin
         rsp_valid <= g_seg[SEGS-1].act_q;
         if (g_seg[SEGS-1].act_q) begin
            rsp_hit       <= f_hit;
            rsp_idx       <= f_idx;
            rsp_vec       <= g_seg[SEGS-1].surv_o;
            rsp_seg_evals <= g_seg[SEGS-1].ev_q + EV_W'(g_seg[SEGS-1].n_ev);
            rsp_grp_ens   <= g_seg[SEGS-1].ge_q + GE_W'(g_seg[SEGS-1].n_ge);
         end
      end
   end

   // R3: reported row is a matching row
   p_idx_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> rsp_vec[rsp_idx]);

   // R3: no matching row below the reported one
   p_idx_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> ((rsp_vec & ((WORDS'(1) << rsp_idx) - WORDS'(1))) == '0));

   // R3: a miss carries an empty vector
   p_miss_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_vec == '0));

   // R5: each refreshed group accounts for at least one comparison
   p_grp_le_eval_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (EV_W'(rsp_grp_ens) <= rsp_seg_evals));

   // R6: an update only happens with an empty pipeline
   p_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !rsp_valid);

endmodule

// File: tb/test_tmatch_pipe.sv
`timescale 1ns/1ps
module test_tmatch_pipe;

   localparam int WORDS      = 16;
   localparam int KEY_W      = 20;
   localparam int SEG0_W     = 2;
   localparam int SEGS       = 4;
   localparam int GROUP_ROWS = 4;
   localparam int REST_W     = (KEY_W - SEG0_W) / (SEGS - 1);
   localparam int GROUPS     = WORDS / GROUP_ROWS;
   localparam int IW         = $clog2(WORDS);
   localparam int EV_W       = $clog2(WORDS * SEGS + 1);
   localparam int GE_W       = $clog2(GROUPS * SEGS + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              srch_valid = 1'b0;
   logic [KEY_W-1:0]  srch_key = '0;
   logic              srch_ready;
   logic              wr_en = 1'b0;
   logic [IW-1:0]     wr_addr = '0;
   logic              wr_live = 1'b0;
   logic [KEY_W-1:0]  wr_value = '0;
   logic [KEY_W-1:0]  wr_care = '0;
   logic              wr_ack;
   logic              rsp_valid;
   logic              rsp_hit;
   logic [IW-1:0]     rsp_idx;
   logic [WORDS-1:0]  rsp_vec;
   logic [EV_W-1:0]   rsp_seg_evals;
   logic [GE_W-1:0]   rsp_grp_ens;

   always #4 clk = ~clk;

   tmatch_pipe #(.WORDS(WORDS), .KEY_W(KEY_W), .SEG0_W(SEG0_W), .SEGS(SEGS),
                 .GROUP_ROWS(GROUP_ROWS)) i_tmatch_pipe (
      .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
      .srch_ready(srch_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_live(wr_live),
      .wr_value(wr_value), .wr_care(wr_care), .wr_ack(wr_ack), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_vec(rsp_vec),
      .rsp_seg_evals(rsp_seg_evals), .rsp_grp_ens(rsp_grp_ens));

   typedef struct {
      longint           exp_cyc;
      logic [WORDS-1:0] vec;
      int               ev;
      int               ge;
   } exp_t;

   exp_t   q[$];
   int     n_chk = 0;
   int     n_fail = 0;
   int     n_push = 0;
   int     n_rsp = 0;
   longint cyc = 0;
   bit     done = 1'b0;
   int     last_ev = -1;
   int     last_ge = -1;
   int     last_idx = -1;
   int     last_hit = -1;

   logic             m_live [WORDS];
   logic [KEY_W-1:0] m_val  [WORDS];
   logic [KEY_W-1:0] m_care [WORDS];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lo_of(input int k);
      return (k == 0) ? 0 : SEG0_W + (k - 1) * REST_W;
   endfunction

   function automatic int w_of(input int k);
      return (k == 0) ? SEG0_W : REST_W;
   endfunction

   // reference: slice-by-slice candidate filtering (R1, R4, R5)
   function automatic exp_t predict(input logic [KEY_W-1:0] key);
      exp_t e;
      logic [WORDS-1:0] s;
      for (int r = 0; r < WORDS; r++) s[r] = m_live[r];
      e.ev = 0;
      e.ge = 0;
      e.exp_cyc = 0;
      for (int k = 0; k < SEGS; k++) begin
         e.ev += $countones(s);
         for (int g = 0; g < GROUPS; g++)
            if (|s[g*GROUP_ROWS +: GROUP_ROWS]) e.ge++;
         for (int r = 0; r < WORDS; r++)
            for (int b = lo_of(k); b < lo_of(k) + w_of(k); b++)
               if (m_care[r][b] && (m_val[r][b] != key[b])) s[r] = 1'b0;
      end
      e.vec = s;
      return e;
   endfunction

   function automatic int low_idx(input logic [WORDS-1:0] v);
      int res = 0;
      for (int i = WORDS - 1; i >= 0; i--) if (v[i]) res = i;
      return res;
   endfunction

   // response monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R8 answer to a refused key", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            n_rsp++;
            chk(cyc == e.exp_cyc, "R2 latency", cyc, e.exp_cyc);
            chk(rsp_vec == e.vec, "R1 match vector", longint'(rsp_vec), longint'(e.vec));
            chk(rsp_hit == (|e.vec), "R3 hit flag", rsp_hit, |e.vec);
            chk(int'(rsp_idx) == low_idx(e.vec), "R3 lowest row", rsp_idx, low_idx(e.vec));
            chk(int'(rsp_seg_evals) == e.ev, "R4 slice comparisons", rsp_seg_evals, e.ev);
            chk(int'(rsp_grp_ens) == e.ge, "R5 group refreshes", rsp_grp_ens, e.ge);
            last_ev  = int'(rsp_seg_evals);
            last_ge  = int'(rsp_grp_ens);
            last_idx = int'(rsp_idx);
            last_hit = int'(rsp_hit);
         end
      end
   end

   task automatic do_search(input logic [KEY_W-1:0] key);
      exp_t e;
      @(negedge clk);
      srch_valid = 1'b1;
      srch_key   = key;
      if (!wr_en) begin
         e = predict(key);
         e.exp_cyc = cyc + 1 + SEGS;
         q.push_back(e);
         n_push++;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         srch_valid = 1'b0;
      end
   endtask

   task automatic do_write(input int addr, input logic [KEY_W-1:0] val,
                           input logic [KEY_W-1:0] care, input bit live, input bit poke);
      int pend;
      @(negedge clk);
      srch_valid = poke;
      srch_key   = KEY_W'($urandom);
      wr_en      = 1'b1;
      wr_addr    = IW'(addr);
      wr_value   = val;
      wr_care    = care;
      wr_live    = live;
      #1;
      chk(srch_ready == 1'b0, "R6 ready low during update", srch_ready, 0);
      forever begin
         pend = 0;
         foreach (q[i]) if (q[i].exp_cyc > cyc) pend++;
         chk(wr_ack == (pend == 0), "R6 update waits for empty stages", wr_ack, pend == 0);
         if (wr_ack) break;
         @(negedge clk);
         #1;
      end
      m_live[addr] = live;
      m_val[addr]  = val & care;
      m_care[addr] = care;
      @(negedge clk);
      wr_en      = 1'b0;
      srch_valid = 1'b0;
   endtask

   function automatic logic [KEY_W-1:0] gen_key();
      logic [KEY_W-1:0] k;
      int r;
      k = KEY_W'($urandom);
      if (($urandom % 100) < 70) begin
         r = $urandom % WORDS;
         k = (m_val[r] & m_care[r]) | (k & ~m_care[r]);
         if (($urandom % 100) < 40) k[$urandom % KEY_W] ^= 1'b1;
      end
      return k;
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [KEY_W-1:0] kd;
      void'($urandom(32'h1c3a_55e1));
      for (int r = 0; r < WORDS; r++) begin
         m_live[r] = 1'b0;
         m_val[r]  = '0;
         m_care[r] = '0;
      end
      repeat (3) @(negedge clk);
      chk(rsp_valid == 1'b0, "R7 no answer in reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(srch_ready == 1'b1, "R6 ready with no update", srch_ready, 1);
      chk(wr_ack == 1'b0, "R6 no ack without request", wr_ack, 0);

      // R7: empty table after reset
      do_search(KEY_W'($urandom));
      idle(SEGS + 2);
      chk(last_hit == 0 && last_ev == 0 && last_ge == 0, "R7 empty table", last_ev + last_ge + last_hit, 0);

      // R3: wildcard row 9 and exact row 3
      kd = 20'h5_A3C6;
      do_write(9, '0, '0, 1'b1, 1'b0);
      do_write(3, kd, '1, 1'b1, 1'b0);
      do_search(kd);
      idle(SEGS + 2);
      chk(last_idx == 3, "R3 lower row wins", last_idx, 3);
      do_search(kd ^ 20'h1);              // row 3 drops in slice 0
      do_search(kd ^ 20'h8_0000);         // row 3 drops in the last slice
      idle(SEGS + 2);
      chk(last_idx == 9, "R3 only wildcard left", last_idx, 9);

      // R5: only group 0 and group 3 populated
      do_write(9, '0, '0, 1'b0, 1'b0);
      do_write(14, kd ^ 20'h4_0000, '1, 1'b1, 1'b0);
      do_search(kd);
      do_search(kd ^ 20'h0_0100);
      idle(SEGS + 2);

      // R2: back-to-back keys
      for (int i = 0; i < 12; i++) do_search(gen_key());
      // R6, R8: update requested while keys are in flight, with a key offered
      do_write(7, kd, 20'hF_0F0F, 1'b1, 1'b1);
      do_search(kd);
      idle(SEGS + 2);
      chk(n_rsp == n_push, "R8 refused keys give no answer", n_rsp, n_push);

      // random table and traffic
      for (int r = 0; r < WORDS; r++)
         do_write(r, KEY_W'($urandom), KEY_W'($urandom | $urandom), ($urandom % 8) != 0, 1'b0);
      for (int i = 0; i < 600; i++) begin
         int sel;
         sel = $urandom % 100;
         if (sel < 5)
            do_write($urandom % WORDS, KEY_W'($urandom), KEY_W'($urandom | $urandom),
                     ($urandom % 6) != 0, ($urandom % 2) == 1);
         else if (sel < 85)
            do_search(gen_key());
         else
            idle(1);
      end
      idle(SEGS + 3);
      chk(n_rsp == n_push, "R8 every accepted key answered once", n_rsp, n_push);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule